// File: doc/BRIEF.md
# Kick Watchdog Supervisor with Reset Stretcher

This block watches a software heartbeat. A processor toggles a kick input now and then. Each change of level, rising or falling, restarts a cycle counter. If the counter reaches a programmed limit before the next change, the supervisor reports a fault. Timing is counted in clock cycles, and the limit is a run-time input.

The supervisor has two behaviours, picked by a mode input. In flag mode a missed kick pulls an active-low fault output down. That output stays down, with the counter frozen at zero, until a new kick edge arrives or the system reset is asserted again. In reboot mode the fault output is never used. A missed kick instead produces an active-low reset pulse of programmable width, and timing starts again once the pulse ends.

A disable input stops all expiry. The kick input passes through a synchronizer that comes out of reset at logic high, so an idle high line is never read as activity.

Top module: `wdt_supervisor`

## Requirements
- R1: While `sys_rst_n` is low, `wdog_n` is high, the timer count is zero and `rst_out_n` is low.
- R2: The timer starts counting on the first rising clock edge after `sys_rst_n` goes high.
- R3: A change of level on `kick`, rising or falling, clears the timer on the third rising edge after the change (two synchronizer stages plus the timer register). Toggling `kick` every k cycles prevents a fault exactly when k is not greater than the effective limit.
- R4: In flag mode (`mode_sel` = 0) with no kicks, `wdog_n` goes low just after rising edge number Teff after release, where Teff = `tmo_cycles`. A `tmo_cycles` of 0 acts as 1.
- R5: Once low, `wdog_n` stays low and the count stays at zero until a kick edge clears it on the third edge after the kick. The next fault then needs a full Teff edges.
- R6: In reboot mode (`mode_sel` = 1), `wdog_n` stays high. A missed kick drives `rst_out_n` low for exactly Peff cycles, starting after edge Teff. Peff = `pulse_cycles`, and 0 acts as 1. The next pulse starts Teff edges after the previous one ends.
- R7: While `wd_disable` is high, no fault and no reset pulse occurs. A standing fault is cleared to `wdog_n` high on the next edge.
- R8: The synchronizer resets to logic high. A `kick` held high through reset release gives no edge. A `kick` held low through reset release counts as one edge.
- R9: Kick edges that arrive while the reset pulse is active are ignored, and the timer stays at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| sys_rst_n | input | 1 | Active-low system reset request (asynchronous assert) |
| kick | input | 1 | Heartbeat from software; either edge counts |
| tmo_cycles | input | TMO_W | Watchdog limit in cycles (0 treated as 1) |
| pulse_cycles | input | PLS_W | Reboot pulse width in cycles (0 treated as 1) |
| wd_disable | input | 1 | High stops all expiry |
| mode_sel | input | 1 | 0 = flag mode, 1 = reboot mode |
| wdog_n | output | 1 | Active-low watchdog fault (flag mode) |
| rst_out_n | output | 1 | Active-low reset out: the system reset request merged with the reboot pulse |

## Verification
The limit is swept from 0 to 9 with no kicks. This tells exact expiry timing apart from off-by-one and the zero-as-one rule. A grid of limits against kick toggle periods separates "kick period equal to the limit" (safe) from "one cycle longer" (fault), and checks that both edge polarities clear the timer. In reboot mode, a grid of limits and pulse widths measures pulse start, pulse length and restart spacing. Targeted runs cover fault latching and recovery, disable, kicks during a pulse, and `kick` held low through reset release.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
   typedef enum logic {
      WD_MODE_FLAG   = 1'b0,
      WD_MODE_REBOOT = 1'b1
   } wd_mode_e;

   localparam int unsigned WD_MIN_SYNC = 2;
   localparam int unsigned WD_MIN_W    = 2;
endpackage

// File: rtl/wdt_kick_sync.sv
module wdt_kick_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic kick,
   output logic kick_edge
);
   logic [STAGES-1:0] chain;
   logic              last_q;

   generate
      for (genvar g = 0; g < STAGES; g++) begin : g_stage
         if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[0] <= 1'b1;
               else        chain[0] <= kick;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[g] <= 1'b1;
               else        chain[g] <= chain[g-1];
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) last_q <= 1'b1;
      else        last_q <= chain[STAGES-1];
   end

   assign kick_edge = chain[STAGES-1] ^ last_q;
endmodule

// File: rtl/wdt_timer.sv
module wdt_timer #(
   parameter int unsigned CW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          hold,
   input  logic          dis,
   input  logic          reboot,
   input  logic [CW-1:0] limit,
   output logic [CW-1:0] cnt,
   output logic          expired,
   output logic          fire
);
   localparam logic [CW:0] ONE = {{CW{1'b0}}, 1'b1};

   logic [CW:0] limit_eff;
   logic [CW:0] cnt_nxt;
   logic        reach;
   logic        live;

   assign limit_eff = (limit == '0) ? ONE : {1'b0, limit};
   assign cnt_nxt   = {1'b0, cnt} + ONE;
   assign reach     = (cnt_nxt >= limit_eff);
   assign live      = !dis && !hold && !clr && !expired;
   assign fire      = live && reach && reboot;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt     <= '0;
         expired <= 1'b0;
      end else if (dis) begin
         cnt     <= '0;
         expired <= 1'b0;
      end else if (hold) begin
         cnt     <= '0;
      end else if (clr) begin
         cnt     <= '0;
         expired <= 1'b0;
      end else if (expired) begin
         cnt     <= '0;
      end else if (reach) begin
         cnt     <= '0;
         expired <= !reboot;
      end else begin
         cnt     <= cnt_nxt[CW-1:0];
      end
   end
endmodule

// File: rtl/wdt_pulse.sv
module wdt_pulse #(
   parameter int unsigned PW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          fire,
   input  logic [PW-1:0] width,
   output logic          active
);
   localparam logic [PW-1:0] ONE = {{(PW-1){1'b0}}, 1'b1};

   logic [PW-1:0] left_q;
   logic [PW-1:0] width_eff;

   assign width_eff = (width == '0) ? ONE : width;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active <= 1'b0;
         left_q <= '0;
      end else if (fire) begin
         active <= 1'b1;
         left_q <= width_eff;
      end else if (active) begin
         if (left_q <= ONE) begin
            active <= 1'b0;
            left_q <= '0;
         end else begin
            left_q <= left_q - ONE;
         end
      end
   end
endmodule

// File: rtl/wdt_supervisor.sv
module wdt_supervisor
   import wdt_pkg::*;
#(
   parameter int unsigned TMO_W       = 16,
   parameter int unsigned PLS_W       = 16,
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          REBOOT_EN   = 1'b1
) (
   input  logic             clk,
   input  logic             sys_rst_n,
   input  logic             kick,
   input  logic [TMO_W-1:0] tmo_cycles,
   input  logic [PLS_W-1:0] pulse_cycles,
   input  logic             wd_disable,
   input  logic             mode_sel,
   output logic             wdog_n,
   output logic             rst_out_n
);
   generate
      if (SYNC_STAGES < WD_MIN_SYNC) begin : g_bad_sync
         initial $error("SYNC_STAGES must be at least 2");
      end
      if (TMO_W < WD_MIN_W) begin : g_bad_tmo
         initial $error("TMO_W must be at least 2");
      end
      if (PLS_W < WD_MIN_W) begin : g_bad_pls
         initial $error("PLS_W must be at least 2");
      end
   endgenerate

   wd_mode_e         mode;
   logic             kick_edge;
   logic [TMO_W-1:0] tmr_cnt;
   logic             tmr_expired;
   logic             tmr_fire;
   logic             pulse_active;
   logic             reboot_sel;

   assign mode = wd_mode_e'(mode_sel);

   wdt_kick_sync #(.STAGES(SYNC_STAGES)) i_sync (
      .clk       (clk),
      .rst_n     (sys_rst_n),
      .kick      (kick),
      .kick_edge (kick_edge)
   );

   generate
      if (REBOOT_EN) begin : g_reboot
         assign reboot_sel = (mode == WD_MODE_REBOOT);
         wdt_pulse #(.PW(PLS_W)) i_pulse (
            .clk    (clk),
            .rst_n  (sys_rst_n),
            .fire   (tmr_fire),
            .width  (pulse_cycles),
            .active (pulse_active)
         );
      end else begin : g_flag_only
         logic unused_pulse;
         assign unused_pulse = ^{pulse_cycles, tmr_fire, mode};
         assign reboot_sel   = 1'b0;
         assign pulse_active = 1'b0;
      end
   endgenerate

   wdt_timer #(.CW(TMO_W)) i_timer (
      .clk     (clk),
      .rst_n   (sys_rst_n),
      .clr     (kick_edge),
      .hold    (pulse_active),
      .dis     (wd_disable),
      .reboot  (reboot_sel),
      .limit   (tmo_cycles),
      .cnt     (tmr_cnt),
      .expired (tmr_expired),
      .fire    (tmr_fire)
   );

   assign wdog_n    = !tmr_expired;
   assign rst_out_n = sys_rst_n && !pulse_active;
endmodule

// File: rtl/wdt_supervisor_chk.sv
module wdt_supervisor_chk #(
   parameter int unsigned CW = 16
) (
   input logic          clk,
   input logic          sys_rst_n,
   input logic          kick_edge,
   input logic [CW-1:0] tmr_cnt,
   input logic          wd_disable,
   input logic          mode_sel,
   input logic          wdog_n,
   input logic          rst_out_n
);
   AST_RESET_STATE: assert property (@(posedge clk)
      !sys_rst_n |-> (tmr_cnt == '0 && wdog_n && !rst_out_n)); // R1

   AST_KICK_CLEARS: assert property (@(posedge clk) disable iff (!sys_rst_n)
      kick_edge |=> (tmr_cnt == '0)); // R3

   AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (!sys_rst_n)
      (!wdog_n && !kick_edge && !wd_disable) |=> !wdog_n); // R5

   AST_FAULT_FROZEN: assert property (@(posedge clk) disable iff (!sys_rst_n)
      !wdog_n |-> (tmr_cnt == '0)); // R5

   AST_REBOOT_NO_FLAG: assert property (@(posedge clk) disable iff (!sys_rst_n)
      (mode_sel && wdog_n) |=> wdog_n); // R6

   AST_DISABLE_HIGH: assert property (@(posedge clk) disable iff (!sys_rst_n)
      wd_disable |=> wdog_n); // R7

   AST_PULSE_HOLDS: assert property (@(posedge clk) disable iff (!sys_rst_n)
      !rst_out_n |-> (tmr_cnt == '0)); // R9
endmodule

bind wdt_supervisor wdt_supervisor_chk #(.CW(TMO_W)) i_chk (
   .clk        (clk),
   .sys_rst_n  (sys_rst_n),
   .kick_edge  (kick_edge),
   .tmr_cnt    (tmr_cnt),
   .wd_disable (wd_disable),
   .mode_sel   (mode_sel),
   .wdog_n     (wdog_n),
   .rst_out_n  (rst_out_n)
);

// File: tb/test_wdt_supervisor.sv
module test_wdt_supervisor;
   logic        clk = 1'b0;
   logic        sys_rst_n = 1'b1;
   logic        kick = 1'b1;
   logic [15:0] tmo_cycles = 16'd4;
   logic [15:0] pulse_cycles = 16'd1;
   logic        wd_disable = 1'b0;
   logic        mode_sel = 1'b0;
   logic        wdog_n;
   logic        rst_out_n;

   int checks = 0;
   int errors = 0;

   always #5 clk = ~clk;

   wdt_supervisor i_wdt_supervisor (
      .clk          (clk),
      .sys_rst_n    (sys_rst_n),
      .kick         (kick),
      .tmo_cycles   (tmo_cycles),
      .pulse_cycles (pulse_cycles),
      .wd_disable   (wd_disable),
      .mode_sel     (mode_sel),
      .wdog_n       (wdog_n),
      .rst_out_n    (rst_out_n)
   );

   task automatic check_eq(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   // Asserts reset for three cycles, releases at a falling edge.
   task automatic do_reset();
      @(negedge clk);
      sys_rst_n = 1'b0;
      repeat (3) @(negedge clk);
      sys_rst_n = 1'b1;
   endtask

   function automatic int eff(input int v);
      return (v == 0) ? 1 : v;
   endfunction

   initial begin
      int first_low;
      int seen_low;
      int pend;
      int second;
      #2 sys_rst_n = 1'b0;
      repeat (2) @(negedge clk);
      // R1: reset state
      check_eq("R1 wdog_n in reset", int'(wdog_n), 1);
      check_eq("R1 rst_out_n in reset", int'(rst_out_n), 0);
      sys_rst_n = 1'b1;

      // R2 / R4: limit sweep, no kicks, flag mode
      for (int t = 0; t < 10; t++) begin
         tmo_cycles = 16'(t);
         do_reset();
         first_low = -1;
         for (int c = 1; c <= 20; c++) begin
            step();
            if (!wdog_n && first_low < 0) first_low = c;
         end
         check_eq($sformatf("R4 R2 first fault edge, limit %0d", t), first_low, eff(t));
      end

      // R3: periodic kick grid
      for (int t = 1; t <= 6; t++) begin
         for (int k = 1; k <= 8; k++) begin
            tmo_cycles = 16'(t);
            kick = 1'b1;
            do_reset();
            kick = 1'b0;
            seen_low = 0;
            for (int c = 1; c <= 40; c++) begin
               step();
               if (c >= 4 && !wdog_n) seen_low = 1;
               if (c % k == 0) kick = ~kick;
            end
            check_eq($sformatf("R3 fault with limit %0d period %0d", t, k),
                     seen_low, (k > t) ? 1 : 0);
         end
      end
      kick = 1'b1;

      // R5: latch and recovery
      tmo_cycles = 16'd4;
      do_reset();
      repeat (3) step();
      check_eq("R5 high before limit", int'(wdog_n), 1);
      step();
      check_eq("R5 low at limit", int'(wdog_n), 0);
      repeat (10) step();
      check_eq("R5 stays low", int'(wdog_n), 0);
      kick = 1'b0;
      repeat (2) step();
      check_eq("R5 still low two edges after kick", int'(wdog_n), 0);
      step();
      check_eq("R5 cleared third edge after kick", int'(wdog_n), 1);
      repeat (3) step();
      check_eq("R5 full limit before next fault", int'(wdog_n), 1);
      step();
      check_eq("R5 next fault after full limit", int'(wdog_n), 0);
      // R1: reset while faulted restores high at once
      @(negedge clk);
      sys_rst_n = 1'b0;
      #1;
      check_eq("R1 reset clears fault", int'(wdog_n), 1);
      check_eq("R1 rst_out_n low in reset", int'(rst_out_n), 0);
      kick = 1'b1;

      // R8: kick high vs low through release
      tmo_cycles = 16'd4;
      kick = 1'b0;
      do_reset();
      first_low = -1;
      for (int c = 1; c <= 20; c++) begin
         step();
         if (!wdog_n && first_low < 0) first_low = c;
      end
      check_eq("R8 low kick at release counts as edge", first_low, 7);
      kick = 1'b1;

      // R7: disable
      tmo_cycles = 16'd3;
      wd_disable = 1'b1;
      do_reset();
      seen_low = 0;
      for (int c = 1; c <= 20; c++) begin
         step();
         if (!wdog_n) seen_low = 1;
      end
      check_eq("R7 no fault while disabled", seen_low, 0);
      wd_disable = 1'b0;
      repeat (2) step();
      check_eq("R7 counting after enable", int'(wdog_n), 1);
      step();
      check_eq("R7 fault after enable", int'(wdog_n), 0);
      wd_disable = 1'b1;
      step();
      check_eq("R7 disable clears fault", int'(wdog_n), 1);
      mode_sel = 1'b1;
      do_reset();
      seen_low = 0;
      for (int c = 1; c <= 20; c++) begin
         step();
         if (!rst_out_n) seen_low = 1;
      end
      check_eq("R7 no reboot pulse while disabled", seen_low, 0);
      wd_disable = 1'b0;

      // R6: reboot mode grid
      for (int ti = 0; ti < 4; ti++) begin
         for (int pi = 0; pi < 5; pi++) begin
            int t;
            int p;
            t = (ti == 0) ? 0 : 2 * ti - 1;
            p = (pi == 0) ? 0 : ((pi == 4) ? 7 : (1 << (pi - 1)));
            tmo_cycles = 16'(t);
            pulse_cycles = 16'(p);
            do_reset();
            first_low = -1; pend = -1; second = -1; seen_low = 0;
            for (int c = 1; c <= 60; c++) begin
               step();
               if (!wdog_n) seen_low = 1;
               if (!rst_out_n && first_low < 0) first_low = c;
               if (first_low >= 0 && pend < 0 && rst_out_n) pend = c;
               if (pend >= 0 && !rst_out_n && second < 0) second = c;
            end
            check_eq($sformatf("R6 pulse start t%0d p%0d", t, p), first_low, eff(t));
            check_eq($sformatf("R6 pulse end t%0d p%0d", t, p), pend, eff(t) + eff(p));
            check_eq($sformatf("R6 next pulse t%0d p%0d", t, p), second,
                     2 * eff(t) + eff(p));
            check_eq($sformatf("R6 wdog_n high t%0d p%0d", t, p), seen_low, 0);
         end
      end

      // R9: kick during pulse ignored
      tmo_cycles = 16'd5;
      pulse_cycles = 16'd7;
      do_reset();
      repeat (5) step();
      check_eq("R9 pulse begun", int'(rst_out_n), 0);
      kick = 1'b0;
      pend = -1; second = -1;
      for (int c = 6; c <= 40; c++) begin
         step();
         if (pend < 0 && rst_out_n) pend = c;
         if (pend >= 0 && !rst_out_n && second < 0) second = c;
      end
      check_eq("R9 pulse width kept", pend, 12);
      check_eq("R9 next pulse after full limit", second, 17);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule